// File: doc/BRIEF.md
# Parallel Bus Strobe Timing Generator

This block produces the control strobes for a single access on an external 8-bit host-style parallel bus. Each access starts with an address-latch phase and ends with a data phase. The address-latch phase drives the address-latch enable strobe. The data phase drives either the read strobe or the write strobe. A chip-select line stays asserted through both phases. When the access has finished, a one-clock done pulse reports it.

Every chip-select has its own strobe polarities, a write wait-state code and a trim bit. These per-select settings apply only while the per-select configuration enable is high. While that enable is low, every access uses the settings of chip-select 0. The write data phase grows in steps of two clocks, and the trim bit removes one clock for odd lengths. Burst mode shortens each data strobe to a single clock and disregards the wait-state setting. The configuration and the access direction are captured when an access starts, so changes made while an access runs have no effect on it.

Top module: `pbus_strobe_gen`

## Requirements
- R1: After reset, ale_o, rd_o and wr_o are high (the active-low default), every cs_n_o bit is high and done_o is low.
- R2: When start_i is sampled high while idle, the next clock is the address phase. It lasts exactly one clock, ALE is at its active level and the chosen chip-select is low. The data strobe becomes active on the clock after that.
- R3: A write outside burst mode with wait-state code c (2-bit field, value 0..3) keeps wr_o active for 2*(c+1) clocks, which gives 2, 4, 6 or 8.
- R4: When the trim bit of the effective settings is set, the active write strobe of a non-burst write is exactly one clock shorter than R3 gives.
- R5: The address phase is one clock for every wait-state code and trim value, so wait states only delay the trailing edge of the write strobe.
- R6: In burst mode the data strobe is active for exactly one clock, whatever the wait-state code and trim bit are.
- R7: Outside burst mode the read strobe is active for exactly 2 clocks.
- R8: Per-select polarity bits are 1 for active high and 0 for active low. Bit k of rd_pol_i, wr_pol_i and ale_pol_i belongs to chip-select k. Between accesses, each strobe rests at the inactive level of the most recent access.
- R9: When percs_en_i is low, every access uses the polarity, wait-state and trim settings of chip-select 0. cs_n_o still drives the line that cs_sel_i selects.
- R10: done_o is high for exactly one clock, in the first clock after the data strobe ends. In that same clock every cs_n_o bit is high again.
- R11: A start_i pulse that arrives during an access is ignored. The running access keeps its chip-select, direction and length, and no new access follows it.
- R12: Wait-state code k is bits [2k+1:2k] of wr_ws_i, and the trim bit for chip-select k is bit k of ws_trim_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin one access |
| rd_nwr_i | input | 1 | 1 = read access, 0 = write access |
| cs_sel_i | input | CS_W | Index of the chip-select used by the access |
| percs_en_i | input | 1 | Enables per-select settings; when low, chip-select 0 settings apply to all |
| burst_i | input | 1 | Burst mode: one-clock data strobe |
| rd_pol_i | input | NUM_CS | Read strobe polarity per select (1 = active high) |
| wr_pol_i | input | NUM_CS | Write strobe polarity per select (1 = active high) |
| ale_pol_i | input | NUM_CS | Address-latch strobe polarity per select (1 = active high) |
| wr_ws_i | input | NUM_CS*WS_W | Write wait-state code per select |
| ws_trim_i | input | NUM_CS | Trim bit per select; removes one clock of write strobe |
| ale_o | output | 1 | Address-latch strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| cs_n_o | output | NUM_CS | Chip-select lines, active low |
| done_o | output | 1 | One-clock pulse when an access completes |

## Verification
The bench uses the default parameters, NUM_CS = 2 and WS_W = 2. This keeps the configuration space small enough to sweep every combination of direction, chip-select, enable, burst, wait-state code and trim bit. It also covers eight polarity patterns, and each pattern gives the two selects opposite polarities as well as different wait-state codes and trim bits. Because the selects differ, an access that wrongly uses chip-select 0 settings, or the wrong select's settings, shows up as a wrong strobe level or a wrong strobe length. In every access the bench also pulses start_i during the data phase with the other select and the other direction, to confirm that the running access stays unchanged.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } pbus_state_e;

    typedef struct packed {
        logic rd_hi;
        logic wr_hi;
        logic ale_hi;
    } pbus_pol_t;

endpackage

// File: rtl/pbus_cfg_sel.sv
module pbus_cfg_sel
    import pbus_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int WS_W   = 2,
    parameter int CS_W   = 1
) (
    input  logic [CS_W-1:0]        cs_sel_i,
    input  logic                   percs_en_i,
    input  logic [NUM_CS-1:0]      rd_pol_i,
    input  logic [NUM_CS-1:0]      wr_pol_i,
    input  logic [NUM_CS-1:0]      ale_pol_i,
    input  logic [NUM_CS*WS_W-1:0] wr_ws_i,
    input  logic [NUM_CS-1:0]      ws_trim_i,
    output pbus_pol_t              pol_o,
    output logic [WS_W-1:0]        ws_o,
    output logic                   trim_o
);

    pbus_pol_t       pol_arr [NUM_CS];
    logic [WS_W-1:0] ws_arr  [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign pol_arr[g] = '{rd_hi: rd_pol_i[g], wr_hi: wr_pol_i[g], ale_hi: ale_pol_i[g]};
        assign ws_arr[g]  = wr_ws_i[g*WS_W +: WS_W];
    end

    // Select the effective settings; index 0 when per-select settings are off
    // or when the requested select is out of range.
    always_comb begin
        pol_o  = pol_arr[0];
        ws_o   = ws_arr[0];
        trim_o = ws_trim_i[0];
        if (percs_en_i) begin
            for (int k = 1; k < NUM_CS; k++) begin
                if (cs_sel_i == CS_W'(k)) begin
                    pol_o  = pol_arr[k];
                    ws_o   = ws_arr[k];
                    trim_o = ws_trim_i[k];
                end
            end
        end
    end

endmodule

// File: rtl/pbus_len_calc.sv
module pbus_len_calc #(
    parameter int WS_W  = 2,
    parameter int CNT_W = WS_W + 2
) (
    input  logic             rd_nwr_i,
    input  logic             burst_i,
    input  logic [WS_W-1:0]  ws_i,
    input  logic             trim_i,
    output logic [CNT_W-1:0] len_o
);

    localparam logic [CNT_W-1:0] READ_LEN = CNT_W'(2);

    logic [CNT_W-1:0] ws_ext;
    logic [CNT_W-1:0] wr_len;

    assign ws_ext = CNT_W'(ws_i);

    always_comb begin
        wr_len = (ws_ext + CNT_W'(1)) << 1;
        if (trim_i) begin
            wr_len = wr_len - CNT_W'(1);
        end
        if (burst_i) begin
            len_o = CNT_W'(1);
        end else if (rd_nwr_i) begin
            len_o = READ_LEN;
        end else begin
            len_o = wr_len;
        end
    end

endmodule

// File: rtl/pbus_strobe_drv.sv
module pbus_strobe_drv
    import pbus_pkg::*;
(
    input  logic      ale_act_i,
    input  logic      rd_act_i,
    input  logic      wr_act_i,
    input  pbus_pol_t pol_i,
    output logic      ale_o,
    output logic      rd_o,
    output logic      wr_o
);

    // Active level equals the polarity bit; inactive level is its inverse.
    assign ale_o = ale_act_i ~^ pol_i.ale_hi;
    assign rd_o  = rd_act_i  ~^ pol_i.rd_hi;
    assign wr_o  = wr_act_i  ~^ pol_i.wr_hi;

endmodule

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
    import pbus_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int WS_W   = 2,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   rd_nwr_i,
    input  logic [CS_W-1:0]        cs_sel_i,
    input  logic                   percs_en_i,
    input  logic                   burst_i,
    input  logic [NUM_CS-1:0]      rd_pol_i,
    input  logic [NUM_CS-1:0]      wr_pol_i,
    input  logic [NUM_CS-1:0]      ale_pol_i,
    input  logic [NUM_CS*WS_W-1:0] wr_ws_i,
    input  logic [NUM_CS-1:0]      ws_trim_i,
    output logic                   ale_o,
    output logic                   rd_o,
    output logic                   wr_o,
    output logic [NUM_CS-1:0]      cs_n_o,
    output logic                   done_o
);

    localparam int               CNT_W   = WS_W + 2;
    localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(2 * (1 << WS_W));

    typedef struct packed {
        pbus_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [CS_W-1:0]  cs;
        logic             rnw;
        pbus_pol_t        pol;
    } regs_t;

    regs_t r_d, r_q;

    pbus_pol_t        sel_pol;
    logic [WS_W-1:0]  sel_ws;
    logic             sel_trim;
    logic [CNT_W-1:0] sel_len;

    pbus_cfg_sel #(
        .NUM_CS (NUM_CS),
        .WS_W   (WS_W),
        .CS_W   (CS_W)
    ) u_cfg (
        .cs_sel_i   (cs_sel_i),
        .percs_en_i (percs_en_i),
        .rd_pol_i   (rd_pol_i),
        .wr_pol_i   (wr_pol_i),
        .ale_pol_i  (ale_pol_i),
        .wr_ws_i    (wr_ws_i),
        .ws_trim_i  (ws_trim_i),
        .pol_o      (sel_pol),
        .ws_o       (sel_ws),
        .trim_o     (sel_trim)
    );

    pbus_len_calc #(
        .WS_W  (WS_W),
        .CNT_W (CNT_W)
    ) u_len (
        .rd_nwr_i (rd_nwr_i),
        .burst_i  (burst_i),
        .ws_i     (sel_ws),
        .trim_i   (sel_trim),
        .len_o    (sel_len)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_ADDR;
                    r_d.cnt = sel_len;
                    r_d.cs  = cs_sel_i;
                    r_d.rnw = rd_nwr_i;
                    r_d.pol = sel_pol;
                end
            end
            ST_ADDR: begin
                r_d.st = ST_DATA;
            end
            ST_DATA: begin
                r_d.cnt = r_q.cnt - CNT_W'(1);
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic busy;
    logic ale_act, rd_act, wr_act;

    assign busy    = (r_q.st == ST_ADDR) || (r_q.st == ST_DATA);
    assign ale_act = (r_q.st == ST_ADDR);
    assign rd_act  = (r_q.st == ST_DATA) && r_q.rnw;
    assign wr_act  = (r_q.st == ST_DATA) && !r_q.rnw;
    assign done_o  = (r_q.st == ST_DONE);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
        assign cs_n_o[g] = !(busy && (r_q.cs == CS_W'(g)));
    end

    pbus_strobe_drv u_drv (
        .ale_act_i (ale_act),
        .rd_act_i  (rd_act),
        .wr_act_i  (wr_act),
        .pol_i     (r_q.pol),
        .ale_o     (ale_o),
        .rd_o      (rd_o),
        .wr_o      (wr_o)
    );

    // R2 / R5: the address phase is a single clock, followed by the data phase
    a_r2_addr_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADDR) |=> (r_q.st == ST_DATA));

    // R3 / R4 / R6 / R7: loaded length stays within 1..LEN_MAX
    a_r3_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ADDR) |-> (r_q.cnt >= CNT_W'(1) && r_q.cnt <= LEN_MAX));

    // R10: done is a single-clock pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: no chip-select asserted while idle or done
    a_r10_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n_o));

    // R1: at most one chip-select low at any time
    a_r1_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R11: the captured select and direction do not move during an access
    a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(r_q.cs) && $stable(r_q.rnw)));

endmodule

// File: tb/sim_pbus_strobe_gen.sv
`timescale 1ns/1ps
module sim_pbus_strobe_gen;

    localparam int NUM_CS = 2;
    localparam int WS_W   = 2;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start_i = 1'b0;
    logic                   rd_nwr_i = 1'b0;
    logic [0:0]             cs_sel_i = '0;
    logic                   percs_en_i = 1'b0;
    logic                   burst_i = 1'b0;
    logic [NUM_CS-1:0]      rd_pol_i = '0;
    logic [NUM_CS-1:0]      wr_pol_i = '0;
    logic [NUM_CS-1:0]      ale_pol_i = '0;
    logic [NUM_CS*WS_W-1:0] wr_ws_i = '0;
    logic [NUM_CS-1:0]      ws_trim_i = '0;
    logic                   ale_o, rd_o, wr_o, done_o;
    logic [NUM_CS-1:0]      cs_n_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pbus_strobe_gen #(.NUM_CS(NUM_CS), .WS_W(WS_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rd_nwr_i   (rd_nwr_i),
        .cs_sel_i   (cs_sel_i),
        .percs_en_i (percs_en_i),
        .burst_i    (burst_i),
        .rd_pol_i   (rd_pol_i),
        .wr_pol_i   (wr_pol_i),
        .ale_pol_i  (ale_pol_i),
        .wr_ws_i    (wr_ws_i),
        .ws_trim_i  (ws_trim_i),
        .ale_o      (ale_o),
        .rd_o       (rd_o),
        .wr_o       (wr_o),
        .cs_n_o     (cs_n_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(int b, int r, int w, int t);
        if (b != 0) return 1;
        if (r != 0) return 2;
        return 2 * (w + 1) - t;
    endfunction

    // One access with a stray start pulse during its data phase (R11).
    task automatic run_access(input int cs, input int rnw);
        int e, len, cnt, ale_hi, rd_hi, wr_hi, stb_hi, stb_act;
        logic [NUM_CS-1:0] cs_exp;
        e      = (percs_en_i != 0) ? cs : 0;
        ale_hi = ale_pol_i[e];
        rd_hi  = rd_pol_i[e];
        wr_hi  = wr_pol_i[e];
        stb_hi = (rnw != 0) ? rd_hi : wr_hi;
        len    = exp_len(burst_i, rnw, int'(wr_ws_i[e*WS_W +: WS_W]), ws_trim_i[e]);
        cs_exp = ~(NUM_CS'(1) << cs);

        @(negedge clk);
        cs_sel_i = cs[0:0];
        rd_nwr_i = rnw[0];
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // Address phase
        chk(ale_o == ale_hi[0], "R2 ale active in address phase", ale_o, ale_hi);
        chk(cs_n_o == cs_exp, "R2 chip-select in address phase", cs_n_o, cs_exp);
        stb_act = (rnw != 0) ? rd_o : wr_o;
        chk(stb_act != stb_hi, "R5 data strobe idle in address phase", stb_act, 1 - stb_hi);

        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 1) start_i = 1'b0;
            stb_act = (rnw != 0) ? rd_o : wr_o;
            if (stb_act != stb_hi) break;
            cnt++;
            chk(ale_o != ale_hi[0] && cs_n_o == cs_exp && !done_o,
                "R11 data phase holds select, ale idle", cs_n_o, cs_exp);
            if (i == 0) begin
                start_i  = 1'b1;
                cs_sel_i = ~cs_sel_i;
                rd_nwr_i = ~rd_nwr_i;
            end
        end
        start_i = 1'b0;
        if (burst_i) chk(cnt == len, "R6 burst strobe length", cnt, len);
        else if (rnw != 0) chk(cnt == len, "R7 read strobe length", cnt, len);
        else if (ws_trim_i[e]) chk(cnt == len, "R4 trimmed write length", cnt, len);
        else chk(cnt == len, "R3 write wait-state length", cnt, len);
        chk(done_o == 1'b1, "R10 done after strobe", done_o, 1);
        chk(&cs_n_o, "R10 chip-select released at done", cs_n_o, 3);
        chk(ale_o == !ale_hi[0] && rd_o == !rd_hi[0] && wr_o == !wr_hi[0],
            "R8 strobes at inactive level of access", {ale_o, rd_o, wr_o},
            {!ale_hi[0], !rd_hi[0], !wr_hi[0]});
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single clock", done_o, 0);
        chk(&cs_n_o && ale_o == !ale_hi[0], "R11 no access started by stray pulse",
            {cs_n_o, ale_o}, {2'b11, !ale_hi[0]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ale_o && rd_o && wr_o, "R1 strobes high in reset", {ale_o, rd_o, wr_o}, 7);
        chk(&cs_n_o && !done_o, "R1 selects off, done low", {cs_n_o, done_o}, 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ale_o && rd_o && wr_o && &cs_n_o && !done_o, "R1 idle after reset",
            {ale_o, rd_o, wr_o}, 7);

        // Sweep: R8/R9/R12 via distinct settings per select
        for (int p = 0; p < 8; p++) begin
            rd_pol_i  = {~p[0], p[0]};
            wr_pol_i  = {~p[1], p[1]};
            ale_pol_i = {~p[2], p[2]};
            for (int pe = 0; pe < 2; pe++) begin
                percs_en_i = pe[0];
                for (int b = 0; b < 2; b++) begin
                    burst_i = b[0];
                    for (int w = 0; w < 4; w++) begin
                        for (int t = 0; t < 2; t++) begin
                            wr_ws_i   = {2'(3 - w), 2'(w)};
                            ws_trim_i = {~t[0], t[0]};
                            for (int cs = 0; cs < 2; cs++) begin
                                for (int r = 0; r < 2; r++) begin
                                    run_access(cs, r);
                                end
                            end
                        end
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule